// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter Core

This block keeps time of day and calendar date in a bank of sixteen byte-wide registers on a simple synchronous register bus. The bus has a 4-bit index, a write strobe with write data, a read strobe, and read data that follows the index combinationally. A prescaler outside the block supplies a one-cycle tick enable. Each tick advances a fractional-second counter. When that counter wraps, the carry ripples through seconds, minutes, hours, day of month, month and a two-digit year. All fields are stored in plain binary.

Software reads the time as several separate register reads, so a carry can land between two of them. The block reports this through a carry flag. The flag is raised when a counting tick lands in the same cycle as a strobed read of the fractional counter, or when the seconds field wraps. Software polls and clears the flag to decide whether to read again.

An alarm flag is raised when the time reaches a programmed hours/minutes/seconds value. A stop bit freezes counting so that the whole time and date can be loaded. Single fields can also be written while the clock runs. A handful of bytes serve as general-purpose storage and can be locked by a test bit.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset every time field is 0, day and month are 1, the year is 0, and all flags, enables, control bits and storage bytes are 0. The clock is left running.
- R2: Each tick advances the fractional counter at index 1, which reads as an unsigned count in bits [FRAC_BITS-1:0]. On reaching its all-ones value the counter wraps to 0 and carries into seconds. Writes to index 1 are ignored.
- R3: Seconds (index 2) and minutes (index 3) roll over from 59 to 0, and hours (index 4) from 23 to 0. Each rollover carries into the next field. A field holding a written value above its limit also wraps to 0 on its next advance.
- R4: Day (index 5) wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days, month 2 has 29 days when year mod 4 is 0 and 28 days otherwise, and all other months have 31 days. Month (index 6) wraps from 12 to 1, and year (index 7) wraps from 99 to 0.
- R5: The carry flag, control register A (index 0) bit 1, is set in two cases: a read strobe at index 1 in a cycle where a tick counts, or a seconds wrap from 59 to 0. A read of index 1 with no counting tick leaves it unchanged.
- R6: The alarm flag, index 0 bit 0, is set when a seconds advance brings seconds, minutes and hours equal to the alarm registers at indices 8, 9 and 10.
- R7: A read strobe at index 0 clears both flags. A flag set condition in the same cycle takes priority over the clear.
- R8: Writing index 0 stores bit 4 (carry interrupt enable) and bit 3 (alarm interrupt enable). A 0 written to bit 1 or bit 0 clears that flag, and a 1 leaves it unchanged. Bits 7:5 and 2 read as 0.
- R9: Control register B (index 11) bit 6 is the stop bit. While it is 1, ticks are ignored and all counters hold. When it is cleared, counting resumes from the held values.
- R10: Time and date fields (indices 2 to 7) and alarm fields accept writes while running. A write replaces the count update of that field in the same cycle.
- R11: Index 11 bit 7 is the test bit, and bits [5:0] together with indices 12 to 15 are storage. While the test bit is 1 (its value before the write), writes to the storage are ignored. While it is 0, the storage keeps the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| addr | input | 4 | Register index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; side effects on indices 0 and 1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr |

## Verification
The bench builds the core with FRAC_BITS set to 2, so that four ticks make one second. With this setting, a stop, load and release of 23:59:59 followed by four ticks crosses exactly one seconds carry, whatever the fractional count was. That makes the day, month, leap-February and year-end rollovers reachable in a few cycles each. The same short second lets an alarm match and a carry flag raised by a read overlapping a tick be reached in a handful of ticks.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int FRAC_BITS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam logic [FRAC_BITS-1:0] FRAC_TOP = {FRAC_BITS{1'b1}};

  logic [FRAC_BITS-1:0] frac_q;
  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, yr_q;
  logic [7:0] alm_s, alm_m, alm_h;
  logic       cie_q, aie_q, cf_q, af_q, test_q, stop_q;
  logic [5:0] ramb_q;
  logic [3:0][7:0] ram_q;

  logic run, c_frac, c_sec, c_min, c_hr, c_day, c_mon;
  logic [7:0] dim, n_sec, n_min, n_hr, n_day, n_mon, n_yr;
  logic alarm_hit, cf_set, ctl_rd, ctl_wr;

  assign run    = tick & ~stop_q;
  assign c_frac = run && (frac_q == FRAC_TOP);
  assign c_sec  = c_frac && (sec_q >= 8'd59);
  assign c_min  = c_sec  && (min_q >= 8'd59);
  assign c_hr   = c_min  && (hr_q  >= 8'd23);
  assign c_day  = c_hr   && (day_q >= dim);
  assign c_mon  = c_day  && (mon_q >= 8'd12);

  always_comb begin
    case (mon_q)
      8'd2:                    dim = (yr_q[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: dim = 8'd30;
      default:                 dim = 8'd31;
    endcase
  end

  assign n_sec = c_frac ? (c_sec ? 8'd0 : sec_q + 8'd1) : sec_q;
  assign n_min = c_sec  ? (c_min ? 8'd0 : min_q + 8'd1) : min_q;
  assign n_hr  = c_min  ? (c_hr  ? 8'd0 : hr_q  + 8'd1) : hr_q;
  assign n_day = c_hr   ? (c_day ? 8'd1 : day_q + 8'd1) : day_q;
  assign n_mon = c_day  ? (c_mon ? 8'd1 : mon_q + 8'd1) : mon_q;
  assign n_yr  = c_mon  ? ((yr_q >= 8'd99) ? 8'd0 : yr_q + 8'd1) : yr_q;

  assign alarm_hit = c_frac && (n_sec == alm_s) && (n_min == alm_m) && (n_hr == alm_h);
  assign cf_set    = (run && rd_en && addr == 4'd1) || c_sec;
  assign ctl_rd    = rd_en && addr == 4'd0;
  assign ctl_wr    = wr_en && addr == 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      sec_q  <= 8'd0;
      min_q  <= 8'd0;
      hr_q   <= 8'd0;
      day_q  <= 8'd1;
      mon_q  <= 8'd1;
      yr_q   <= 8'd0;
    end else begin
      frac_q <= run ? frac_q + 1'b1 : frac_q;
      sec_q  <= (wr_en && addr == 4'd2) ? wdata : n_sec;
      min_q  <= (wr_en && addr == 4'd3) ? wdata : n_min;
      hr_q   <= (wr_en && addr == 4'd4) ? wdata : n_hr;
      day_q  <= (wr_en && addr == 4'd5) ? wdata : n_day;
      mon_q  <= (wr_en && addr == 4'd6) ? wdata : n_mon;
      yr_q   <= (wr_en && addr == 4'd7) ? wdata : n_yr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_s  <= 8'd0;
      alm_m  <= 8'd0;
      alm_h  <= 8'd0;
      cie_q  <= 1'b0;
      aie_q  <= 1'b0;
      cf_q   <= 1'b0;
      af_q   <= 1'b0;
      test_q <= 1'b0;
      stop_q <= 1'b0;
      ramb_q <= '0;
      ram_q  <= '0;
    end else begin
      cf_q <= cf_set    | (cf_q & ~ctl_rd & ~(ctl_wr & ~wdata[1]));
      af_q <= alarm_hit | (af_q & ~ctl_rd & ~(ctl_wr & ~wdata[0]));
      if (ctl_wr) begin
        cie_q <= wdata[4];
        aie_q <= wdata[3];
      end
      if (wr_en) begin
        case (addr)
          4'd8:  alm_s <= wdata;
          4'd9:  alm_m <= wdata;
          4'd10: alm_h <= wdata;
          4'd11: begin
            test_q <= wdata[7];
            stop_q <= wdata[6];
            if (!test_q) ramb_q <= wdata[5:0];
          end
          default: ;
        endcase
        if (addr[3:2] == 2'b11 && !test_q) ram_q[addr[1:0]] <= wdata;
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = {3'b000, cie_q, aie_q, 1'b0, cf_q, af_q};
      4'd1:    rdata = 8'(frac_q);
      4'd2:    rdata = sec_q;
      4'd3:    rdata = min_q;
      4'd4:    rdata = hr_q;
      4'd5:    rdata = day_q;
      4'd6:    rdata = mon_q;
      4'd7:    rdata = yr_q;
      4'd8:    rdata = alm_s;
      4'd9:    rdata = alm_m;
      4'd10:   rdata = alm_h;
      4'd11:   rdata = {test_q, stop_q, ramb_q};
      default: rdata = ram_q[addr[1:0]];
    endcase
  end

  assert_frac_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd1 && !tick) |=> $stable(frac_q));

  assert_cf_read_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_q && rd_en && addr == 4'd1) |=> cf_q);

  assert_flags_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd0 && !tick) |=> (!cf_q && !af_q));

  assert_stop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> ($stable(frac_q) && $stable(sec_q) && $stable(min_q) && $stable(day_q)));

  assert_ram_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q && wr_en && addr[3:2] == 2'b11) |=> $stable(ram_q));
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  localparam int FB   = 2;
  localparam int FTOP = (1 << FB) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] addr = 4'd0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rtc_calendar_core #(.FRAC_BITS(FB)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

  int m_frac, m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_as, m_am, m_ah, m_ramb;
  int m_ram [4];
  bit m_cie, m_aie, m_cf, m_af, m_test, m_stop;
  int n_frac, n_sec, n_min, n_hr, n_day, n_mon, n_yr;
  bit scarry, hit, old_test;

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_frac = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0;
      m_as = 0; m_am = 0; m_ah = 0; m_ramb = 0;
      for (int i = 0; i < 4; i++) m_ram[i] = 0;
      m_cie = 0; m_aie = 0; m_cf = 0; m_af = 0; m_test = 0; m_stop = 0;
    end else begin
      n_frac = m_frac; n_sec = m_sec; n_min = m_min; n_hr = m_hr;
      n_day = m_day; n_mon = m_mon; n_yr = m_yr;
      scarry = 0; hit = 0;
      if (tick && !m_stop) begin
        if (m_frac == FTOP) begin
          n_frac = 0;
          if (m_sec >= 59) begin
            n_sec = 0; scarry = 1;
            if (m_min >= 59) begin
              n_min = 0;
              if (m_hr >= 23) begin
                n_hr = 0;
                if (m_day >= days_in(m_mon, m_yr)) begin
                  n_day = 1;
                  if (m_mon >= 12) begin
                    n_mon = 1;
                    n_yr = (m_yr >= 99) ? 0 : m_yr + 1;
                  end else n_mon = m_mon + 1;
                end else n_day = m_day + 1;
              end else n_hr = m_hr + 1;
            end else n_min = m_min + 1;
          end else n_sec = m_sec + 1;
          hit = (n_sec == m_as) && (n_min == m_am) && (n_hr == m_ah);
        end else n_frac = m_frac + 1;
        if (rd_en && addr == 4'd1) scarry = 1;
      end
      if (rd_en && addr == 4'd0) begin m_cf = 0; m_af = 0; end
      if (wr_en && addr == 4'd0) begin
        if (!wdata[1]) m_cf = 0;
        if (!wdata[0]) m_af = 0;
        m_cie = wdata[4]; m_aie = wdata[3];
      end
      if (scarry) m_cf = 1;
      if (hit) m_af = 1;
      m_frac = n_frac; m_sec = n_sec; m_min = n_min; m_hr = n_hr;
      m_day = n_day; m_mon = n_mon; m_yr = n_yr;
      old_test = m_test;
      if (wr_en) begin
        case (addr)
          4'd2: m_sec = wdata;
          4'd3: m_min = wdata;
          4'd4: m_hr = wdata;
          4'd5: m_day = wdata;
          4'd6: m_mon = wdata;
          4'd7: m_yr = wdata;
          4'd8: m_as = wdata;
          4'd9: m_am = wdata;
          4'd10: m_ah = wdata;
          4'd11: begin
            m_test = wdata[7]; m_stop = wdata[6];
            if (!old_test) m_ramb = wdata[5:0];
          end
          4'd12, 4'd13, 4'd14, 4'd15: if (!old_test) m_ram[addr - 12] = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_reg(int a);
    case (a)
      0: return (int'(m_cie) << 4) | (int'(m_aie) << 3) | (int'(m_cf) << 1) | int'(m_af);
      1: return m_frac;
      2: return m_sec;
      3: return m_min;
      4: return m_hr;
      5: return m_day;
      6: return m_mon;
      7: return m_yr;
      8: return m_as;
      9: return m_am;
      10: return m_ah;
      11: return (int'(m_test) << 7) | (int'(m_stop) << 6) | m_ramb;
      default: return m_ram[a - 12];
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R7";
    if (a == 1) return "R2";
    if (a <= 4) return "R3";
    if (a <= 7) return "R4";
    if (a <= 10) return "R6";
    return "R11";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [3:0] a, logic w, logic r, logic [7:0] d, logic t);
    addr = a; wr_en = w; rd_en = r; wdata = d; tick = t;
    @(negedge clk);
    check({tag_of(int'(addr)), " model"}, int'(rdata), exp_reg(int'(addr)));
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(a, 1'b1, 1'b0, d, 1'b0);
  endtask

  task automatic peek(logic [3:0] a, int exp, string tag);
    step(a, 1'b0, 1'b0, 8'd0, 1'b0);
    check(tag, int'(rdata), exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(4'(i), 1'b0, 1'b0, 8'd0, 1'b1);
  endtask

  task automatic load_eod(int day, int mon, int yr);
    wr(4'd11, 8'h40);
    wr(4'd2, 8'd59); wr(4'd3, 8'd59); wr(4'd4, 8'd23);
    wr(4'd5, 8'(day)); wr(4'd6, 8'(mon)); wr(4'd7, 8'(yr));
    wr(4'd11, 8'h00);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 16; a++) step(4'(a), 1'b0, 1'b0, 8'd0, 1'b0);
    peek(4'd0, 0, "R1"); peek(4'd1, 0, "R1"); peek(4'd2, 0, "R1");
    peek(4'd5, 1, "R1"); peek(4'd6, 1, "R1"); peek(4'd7, 0, "R1"); peek(4'd11, 0, "R1");
    // R2 fractional counting and read-only
    ticks(13);
    peek(4'd1, 1, "R2"); peek(4'd2, 3, "R2");
    wr(4'd1, 8'h03);
    peek(4'd1, 1, "R2");
    // R9 stop and resume
    wr(4'd11, 8'h40);
    ticks(6);
    peek(4'd1, 1, "R9"); peek(4'd2, 3, "R9");
    wr(4'd11, 8'h00);
    ticks(2);
    peek(4'd1, 3, "R9");
    // R3 R4 year-end rollover
    wr(4'd11, 8'h40);
    wr(4'd2, 8'd59); wr(4'd3, 8'd59); wr(4'd4, 8'd23);
    wr(4'd5, 8'd31); wr(4'd6, 8'd12); wr(4'd7, 8'd99);
    step(4'd0, 1'b0, 1'b1, 8'd0, 1'b0);
    wr(4'd11, 8'h00);
    ticks(1);
    peek(4'd2, 0, "R3"); peek(4'd3, 0, "R3"); peek(4'd4, 0, "R3");
    peek(4'd5, 1, "R4"); peek(4'd6, 1, "R4"); peek(4'd7, 0, "R4");
    peek(4'd0, 3, "R5");
    step(4'd0, 1'b0, 1'b1, 8'd0, 1'b0);
    peek(4'd0, 0, "R7");
    // R4 month lengths and leap year
    load_eod(28, 2, 4); ticks(4);
    peek(4'd5, 29, "R4"); peek(4'd6, 2, "R4");
    load_eod(29, 2, 4); ticks(4);
    peek(4'd5, 1, "R4"); peek(4'd6, 3, "R4");
    load_eod(28, 2, 5); ticks(4);
    peek(4'd5, 1, "R4"); peek(4'd6, 3, "R4");
    load_eod(30, 4, 5); ticks(4);
    peek(4'd5, 1, "R4"); peek(4'd6, 5, "R4");
    // R6 alarm
    wr(4'd11, 8'h40);
    wr(4'd8, 8'd5); wr(4'd9, 8'd0); wr(4'd10, 8'd0);
    wr(4'd2, 8'd3); wr(4'd3, 8'd0); wr(4'd4, 8'd0);
    step(4'd0, 1'b0, 1'b1, 8'd0, 1'b0);
    wr(4'd11, 8'h00);
    ticks(4);
    peek(4'd0, 0, "R6");
    ticks(4);
    peek(4'd0, 1, "R6");
    // R8 flag write semantics
    wr(4'd11, 8'h40);
    wr(4'd0, 8'h19); peek(4'd0, 8'h19, "R8");
    wr(4'd0, 8'h18); peek(4'd0, 8'h18, "R8");
    wr(4'd0, 8'h1B); peek(4'd0, 8'h18, "R8");
    wr(4'd0, 8'h00); peek(4'd0, 0, "R8");
    // R5 read overlapping a tick
    wr(4'd11, 8'h00);
    step(4'd1, 1'b0, 1'b1, 8'd0, 1'b1);
    peek(4'd0, 2, "R5");
    step(4'd0, 1'b0, 1'b1, 8'd0, 1'b0);
    step(4'd1, 1'b0, 1'b1, 8'd0, 1'b0);
    peek(4'd0, 0, "R5");
    // R10 writes while running
    step(4'd2, 1'b1, 1'b0, 8'd30, 1'b1);
    peek(4'd2, 30, "R10");
    step(4'd3, 1'b1, 1'b0, 8'd7, 1'b1);
    peek(4'd3, 7, "R10");
    step(4'd2, 1'b1, 1'b0, 8'd50, 1'b1);
    peek(4'd2, 50, "R10"); peek(4'd1, 0, "R10");
    // R11 storage and test lock
    wr(4'd11, 8'h80);
    wr(4'd12, 8'hAA); peek(4'd12, 0, "R11");
    wr(4'd11, 8'h3F); peek(4'd11, 0, "R11");
    wr(4'd12, 8'h5A); peek(4'd12, 8'h5A, "R11");
    wr(4'd11, 8'h15); peek(4'd11, 8'h15, "R11");
    wr(4'd15, 8'hC3); peek(4'd15, 8'hC3, "R11");
    // long run compared against the model
    ticks(200);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule